// File: doc/BRIEF.md
# Vector Shift-Left-by-Immediate Unit

This block executes one kind of operation from a SIMD shift-by-immediate instruction group: a logical left shift of every lane of a vector by a constant. It receives a 32-bit instruction word and a 128-bit source operand, qualified by a valid strobe. It then does three things:

- It checks that the word belongs to the shift-left form.
- It derives the lane size, the shift count and the vector width from the packed immediate.
- It returns the shifted vector one clock later.

A word with an all-zero lane-size field belongs to another instruction class and raises a decode-error pulse. A request for 64-bit lanes in a 64-bit vector is reserved and raises a reserved-encoding pulse. Neither error case produces a result.

The lane size and the shift count share one 7-bit immediate. The highest set bit of its upper four bits picks the lane size. The count is the whole 7-bit value minus that lane size. The surrounding pipeline supplies the operand and writes the result back. Register selection fields in the word are carried but not used here.

Top module: `vshl_unit`

## Requirements
- R1: A word is accepted only if bit 31 = 0, bit 29 = 0, bits 28:23 = 011110 and bits 15:10 = 010101. When `in_valid` is high with any other word, all three strobes stay low on the next cycle and `result` keeps its previous value.
- R2: An accepted word with bits 22:19 (the lane-size field, here called `sz4`) equal to 0000 pulses `dec_err` for one cycle. `result` is left unchanged.
- R3: An accepted word with `sz4[3]` = 1 and bit 30 (the wide flag) = 0 pulses `rsv_err` for one cycle. `result` is left unchanged.
- R4: The lane size is 8 bits when `sz4` = 0001, 16 when it is 001x, 32 when it is 01xx and 64 when it is 1xxx.
- R5: The shift count is the unsigned value of bits 22:16 minus the lane size. This covers 0 up to the lane size minus one, including the top count.
- R6: Each lane is shifted left logically by the same count. Zeros fill from the right, and bits leaving the top of a lane are lost rather than entering the next lane.
- R7: With the wide flag at 1 all 128 bits are processed. With it at 0 only operand bits 63:0 are processed and result bits 127:64 are zero.
- R8: `res_valid`, `dec_err` and `rsv_err` reflect the request sampled at the previous rising clock edge. A request in every cycle gives a response in every cycle.
- R9: Exactly one of `res_valid`, `dec_err` and `rsv_err` pulses for each accepted word. None pulses when `in_valid` was low.
- R10: While `rst_n` is low, `result` and all three strobes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe for `insn` and `operand` |
| insn | input | 32 | Instruction word |
| operand | input | 128 | Source vector |
| res_valid | output | 1 | Result strobe, one cycle after an executed request |
| result | output | 128 | Registered shifted vector |
| dec_err | output | 1 | Decode-error pulse (lane-size field all zero) |
| rsv_err | output | 1 | Reserved-encoding pulse (64-bit lanes in a 64-bit vector) |

## Verification
The hardest condition to provoke is a fault that only shows at a lane edge: a carry leaking into the next lane, or a count that is off by one only at its top value. An all-ones operand exposes both. The bench applies it with the largest count for each lane size, so every surviving bit sits next to a lane boundary and any leak or extra shift flips a visible bit. To check that the error and mismatch cases are ignored, the bench first executes a known shift. It then confirms that `result` still holds that value after each rejected word, one fixed bit of the word flipped at a time.

// File: rtl/vshl_pkg.sv
package vshl_pkg;

  localparam int unsigned INSN_W   = 32;
  localparam int unsigned VEC_W    = 128;
  localparam int unsigned HALF_W   = VEC_W / 2;
  localparam int unsigned N_LSZ    = 4;
  localparam int unsigned MIN_LANE = 8;
  localparam int unsigned CNT_W    = 6;

  // Fixed-field positions of the shift-left form
  localparam int unsigned POS_TOP   = 31;
  localparam int unsigned POS_WIDE  = 30;
  localparam int unsigned POS_U     = 29;
  localparam int unsigned GRP_HI    = 28;
  localparam int unsigned GRP_LO    = 23;
  localparam int unsigned SZ_HI     = 22;
  localparam int unsigned SZ_LO     = 19;
  localparam int unsigned SUB_HI    = 18;
  localparam int unsigned SUB_LO    = 16;
  localparam int unsigned OPC_HI    = 15;
  localparam int unsigned OPC_LO    = 10;
  localparam logic [5:0]  GRP_CODE  = 6'b011110;
  localparam logic [5:0]  OPC_CODE  = 6'b010101;

  typedef enum logic [1:0] {
    LSZ_B8  = 2'd0,
    LSZ_B16 = 2'd1,
    LSZ_B32 = 2'd2,
    LSZ_B64 = 2'd3
  } lane_sz_e;

  typedef struct packed {
    logic             hit;
    logic             bad_imm;
    logic             rsv;
    logic             wide;
    lane_sz_e         lsz;
    logic [CNT_W-1:0] cnt;
  } dec_s;

endpackage

// File: rtl/vshl_decode.sv
module vshl_decode
  import vshl_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_s              dec
);

  logic [3:0] sz4;
  logic [2:0] sub3;

  always_comb begin
    sz4  = insn[SZ_HI:SZ_LO];
    sub3 = insn[SUB_HI:SUB_LO];

    dec.hit = !insn[POS_TOP] && !insn[POS_U] &&
              (insn[GRP_HI:GRP_LO] == GRP_CODE) &&
              (insn[OPC_HI:OPC_LO] == OPC_CODE);
    dec.wide    = insn[POS_WIDE];
    dec.bad_imm = (sz4 == 4'b0000);
    dec.rsv     = !dec.bad_imm && sz4[3] && !insn[POS_WIDE];

    // Highest set bit selects the lane size; subtracting the lane size
    // from {sz4,sub3} equals dropping that bit, so the count is a mask.
    unique casez (sz4)
      4'b1???: begin
        dec.lsz = LSZ_B64;
        dec.cnt = {sz4[2:0], sub3};
      end
      4'b01??: begin
        dec.lsz = LSZ_B32;
        dec.cnt = {1'b0, sz4[1:0], sub3};
      end
      4'b001?: begin
        dec.lsz = LSZ_B16;
        dec.cnt = {2'b00, sz4[0], sub3};
      end
      default: begin
        dec.lsz = LSZ_B8;
        dec.cnt = {3'b000, sub3};
      end
    endcase
  end

endmodule

// File: rtl/vshl_lane_shift.sv
module vshl_lane_shift #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [VEC_W-1:0]          din,
  input  logic [$clog2(LANE_W)-1:0] cnt,
  output logic [VEC_W-1:0]          dout
);

  localparam int unsigned N_LANES = VEC_W / LANE_W;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    // Each lane is shifted in isolation: nothing crosses a lane edge
    assign dout[l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W] << cnt;
  end

endmodule

// File: rtl/vshl_unit.sv
module vshl_unit
  import vshl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [VEC_W-1:0]  operand,
  output logic              res_valid,
  output logic [VEC_W-1:0]  result,
  output logic              dec_err,
  output logic              rsv_err
);

  dec_s             dec;
  logic [VEC_W-1:0] shifted [N_LSZ];
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] res_d;
  logic             accept;
  logic             go;
  logic             vld_d, de_d, rv_d;
  logic [VEC_W-1:0] result_q;
  logic             vld_q, de_q, rv_q;
  logic             unused_reg_fields;

  // Register selector fields are used by the surrounding pipeline only
  assign unused_reg_fields = ^insn[OPC_LO-1:0];

  vshl_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  for (genvar g = 0; g < N_LSZ; g++) begin : g_size
    localparam int unsigned LW = MIN_LANE << g;
    vshl_lane_shift #(
      .VEC_W  (VEC_W),
      .LANE_W (LW)
    ) u_shl (
      .din  (operand),
      .cnt  (dec.cnt[$clog2(LW)-1:0]),
      .dout (shifted[g])
    );
  end

  // Next-state logic
  always_comb begin
    picked = shifted[dec.lsz];
    if (!dec.wide) begin
      picked[VEC_W-1:HALF_W] = '0;
    end
    accept = in_valid && dec.hit;
    go     = accept && !dec.bad_imm && !dec.rsv;
    vld_d  = go;
    de_d   = accept && dec.bad_imm;
    rv_d   = accept && dec.rsv;
    res_d  = go ? picked : result_q;
  end

  // Result register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (go) begin
      result_q <= res_d;
    end
  end

  // Strobe registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      de_q  <= 1'b0;
      rv_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      de_q  <= de_d;
      rv_q  <= rv_d;
    end
  end

  assign result    = result_q;
  assign res_valid = vld_q;
  assign dec_err   = de_q;
  assign rsv_err   = rv_q;

endmodule

// File: rtl/vshl_unit_chk.sv
module vshl_unit_chk
  import vshl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [INSN_W-1:0] insn,
  input logic              res_valid,
  input logic [VEC_W-1:0]  result,
  input logic              dec_err,
  input logic              rsv_err
);

  logic fixed_ok;
  assign fixed_ok = (insn[31] == 1'b0) && (insn[29] == 1'b0) &&
                    (insn[28:23] == 6'b011110) && (insn[15:10] == 6'b010101);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, dec_err, rsv_err})); // R9

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(res_valid || dec_err || rsv_err)); // R8

  AST_MISMATCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fixed_ok) |=> !(res_valid || dec_err || rsv_err)); // R1

  AST_RSV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fixed_ok && insn[22] && !insn[30]) |=> rsv_err); // R3

  AST_ERR_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_err || rsv_err) |-> $stable(result)); // R2

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fixed_ok && !insn[30]) |=> (!res_valid || result[127:64] == '0)); // R7

endmodule

bind vshl_unit vshl_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .insn      (insn),
  .res_valid (res_valid),
  .result    (result),
  .dec_err   (dec_err),
  .rsv_err   (rsv_err)
);

// File: tb/vshl_unit_tb.sv
`timescale 1ns/1ps
module vshl_unit_tb;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  insn;
  logic [127:0] operand;
  logic         res_valid;
  logic [127:0] result;
  logic         dec_err;
  logic         rsv_err;

  int checks;
  int errors;
  bit done;
  logic [127:0] last_res;

  vshl_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .insn      (insn),
    .operand   (operand),
    .res_valid (res_valid),
    .result    (result),
    .dec_err   (dec_err),
    .rsv_err   (rsv_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mk(logic q, logic [3:0] sz4, logic [2:0] sub3);
    return {1'b0, q, 1'b0, 6'b011110, sz4, sub3, 6'b010101, 5'd3, 5'd9};
  endfunction

  // Bit-by-bit reference of the per-lane left shift
  function automatic logic [127:0] model(logic [31:0] w, logic [127:0] op);
    logic [127:0] r;
    logic [3:0] h;
    int esz;
    int sh;
    h   = w[22:19];
    esz = h[3] ? 64 : h[2] ? 32 : h[1] ? 16 : 8;
    sh  = int'({h, w[18:16]}) - esz;
    for (int i = 0; i < 128; i++) begin
      int j;
      j = i % esz;
      r[i] = (j >= sh) ? op[i - sh] : 1'b0;
      if (!w[30] && i >= 64) r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req, logic v, logic d, logic r);
    chk({res_valid, dec_err, rsv_err} == {v, d, r}, req,
        {125'd0, res_valid, dec_err, rsv_err}, {125'd0, v, d, r});
  endtask

  // Drive a request for one cycle; outputs are valid at the following negedge
  task automatic issue(logic [31:0] w, logic [127:0] op);
    @(negedge clk);
    in_valid = 1'b1;
    insn     = w;
    operand  = op;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_shift(string req, logic [31:0] w, logic [127:0] op);
    logic [127:0] e;
    e = model(w, op);
    issue(w, op);
    chk(result == e, req, result, e);
    chk_flags({req, " strobe R9"}, 1'b1, 1'b0, 1'b0);
    last_res = e;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_valid = 1'b0;
    insn = '0;
    operand = '0;
    repeat (3) @(negedge clk);
    chk(result == '0, "R10 result", result, '0);
    chk_flags("R10 strobes", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    last_res = '0;
  endtask

  task automatic t_lane8;
    run_shift("R4 R6 8-bit lanes", mk(1'b1, 4'b0001, 3'd3), {128{1'b1}});
    run_shift("R5 R6 8-bit max count", mk(1'b1, 4'b0001, 3'd7), {128{1'b1}});
  endtask

  task automatic t_lane16;
    run_shift("R4 R5 16-bit count 15", mk(1'b1, 4'b0011, 3'd7), {128{1'b1}});
    run_shift("R5 16-bit count 9", mk(1'b1, 4'b0011, 3'd1), 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
  endtask

  task automatic t_lane32;
    run_shift("R5 32-bit count 0", mk(1'b1, 4'b0100, 3'd0), 128'hdead_beef_0bad_f00d_1234_5678_9abc_def0);
    run_shift("R4 R6 32-bit count 31", mk(1'b1, 4'b0111, 3'd7), {128{1'b1}});
  endtask

  task automatic t_lane64;
    run_shift("R4 R5 64-bit count 63", mk(1'b1, 4'b1111, 3'd7), {128{1'b1}});
    run_shift("R6 64-bit count 20", mk(1'b1, 4'b1010, 3'd4), 128'h8000_0000_0000_0001_ffff_0000_ffff_0000);
  endtask

  task automatic t_narrow;
    run_shift("R7 64-bit vector 16-bit lanes", mk(1'b0, 4'b0010, 3'd5), {128{1'b1}});
    chk(result[127:64] == '0, "R7 upper half zero", result, '0);
    run_shift("R7 64-bit vector 8-bit lanes", mk(1'b0, 4'b0001, 3'd1), 128'hffff_ffff_ffff_ffff_0102_0408_1020_4080);
  endtask

  task automatic t_dec_err;
    issue(mk(1'b1, 4'b0000, 3'd5), {128{1'b1}});
    chk_flags("R2 decode error", 1'b0, 1'b1, 1'b0);
    chk(result == last_res, "R2 result held", result, last_res);
    @(negedge clk);
    chk_flags("R2 single pulse", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reserved;
    issue(mk(1'b0, 4'b1000, 3'd2), {128{1'b1}});
    chk_flags("R3 reserved", 1'b0, 1'b0, 1'b1);
    chk(result == last_res, "R3 result held", result, last_res);
    @(negedge clk);
    chk_flags("R3 single pulse", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mismatch;
    int pos [14] = '{31, 29, 28, 27, 26, 25, 24, 23, 15, 14, 13, 12, 11, 10};
    for (int k = 0; k < 14; k++) begin
      logic [31:0] w;
      w = mk(1'b1, 4'b0001, 3'd2);
      w[pos[k]] = ~w[pos[k]];
      issue(w, {128{1'b1}});
      chk_flags($sformatf("R1 flipped bit %0d", pos[k]), 1'b0, 1'b0, 1'b0);
      chk(result == last_res, "R1 result held", result, last_res);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_valid = 1'b0;
    insn     = mk(1'b1, 4'b0001, 3'd1);
    operand  = {128{1'b1}};
    @(negedge clk);
    chk_flags("R9 no request no strobe", 1'b0, 1'b0, 1'b0);
    chk(result == last_res, "R9 result held", result, last_res);
  endtask

  task automatic t_back_to_back;
    logic [31:0] w1, w2, w3;
    logic [127:0] o1, o2, e1, e2;
    w1 = mk(1'b1, 4'b0001, 3'd4);
    w2 = mk(1'b1, 4'b0101, 3'd6);
    w3 = mk(1'b1, 4'b0000, 3'd0);
    o1 = 128'h00ff_00ff_00ff_00ff_00ff_00ff_00ff_00ff;
    o2 = 128'hf0f0_f0f0_0f0f_0f0f_a5a5_a5a5_5a5a_5a5a;
    e1 = model(w1, o1);
    e2 = model(w2, o2);
    @(negedge clk);
    in_valid = 1'b1; insn = w1; operand = o1;
    @(negedge clk);
    chk(result == e1, "R8 first of burst", result, e1);
    chk_flags("R8 first strobe", 1'b1, 1'b0, 1'b0);
    insn = w2; operand = o2;
    @(negedge clk);
    chk(result == e2, "R8 second of burst", result, e2);
    chk_flags("R8 second strobe", 1'b1, 1'b0, 1'b0);
    insn = w3;
    @(negedge clk);
    in_valid = 1'b0;
    chk_flags("R8 R9 error in burst", 1'b0, 1'b1, 1'b0);
    chk(result == e2, "R8 result held after error", result, e2);
    last_res = e2;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    t_reset();
    t_lane8();
    t_lane16();
    t_lane32();
    t_lane64();
    t_narrow();
    t_dec_err();
    t_reserved();
    t_mismatch();
    t_idle();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule